// File: doc/BRIEF.md
# Maskable Interrupt Priority Controller

This block gathers a set of maskable interrupt sources and decides which one, if any, the CPU should take. Every source owns a request flag and a 3-bit priority level. A request is offered to the CPU only when the global enable is on, the flag is set, and the level is strictly above the current processor interrupt level (IPL). Among the offered requests the highest level wins. On a tie, the lowest source index wins.

The winner appears on a registered pending strobe, together with its source index and level. When the CPU acknowledges, the block clears that source's flag and picks again. Software programs the global enable, the IPL and the per-source levels through a small write port. The same port lets software clear request flags. The request flags can be read at all times on a dedicated output.

Write port map:

| Address | Effect |
|---|---|
| 0 | global enable = data bit 0 |
| 1 | IPL = data[2:0] |
| 2 | each data bit k that is 0 clears flag k; a 1 bit leaves flag k unchanged |
| 4+k | level of source k = data[2:0] |

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every request flag is 0, the pending strobe is 0, every level is 0 (disabled), the IPL is 0 and the global enable is 0.
- R2: A high `src_req_i[k]` at a clock edge sets request flag k, which shows on `req_flags_o[k]` after that edge.
- R3: A write to address 2 clears flag k when data bit k is 0 and leaves flag k unchanged when data bit k is 1; a write can never set a flag.
- R4: A request and a software clear of the same flag in one cycle leave the flag set.
- R5: The global enable is written at address 0 (data bit 0). While it is 0, the pending strobe stays 0 whatever the flags, levels and IPL are.
- R6: The level of source k is written at address 4+k (data[2:0], 7 highest). Level 0 keeps that source from ever being offered, even when its flag is set.
- R7: The IPL is written at address 1 (data[2:0]). A source is offered only if its level is strictly greater than the IPL, so IPL 7 blocks every source.
- R8: Among the offered sources the one with the highest level is presented, and among equal levels the one with the lowest index.
- R9: The pending strobe, source index and level are registered and change on the same edge as the state change that causes them. Once a source is presented, it stays presented while it remains eligible and no acknowledge arrives, even if a higher-level request appears meanwhile.
- R10: An acknowledge while the strobe is high clears the presented source's flag on that edge, and the next winner is presented on the same edge. An acknowledge while the strobe is low has no effect. A new request of the presented source in the acknowledge cycle keeps its flag set.
- R11: Writing the enable, the IPL, a level or the flag clear changes only that item; the other settings and the flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock, rising edge |
| rst_n | input | 1 | asynchronous reset, active low |
| src_req_i | input | N_SRC | per-source request, sampled each edge |
| wr_en_i | input | 1 | register write strobe |
| wr_addr_i | input | ADDR_W | register write address |
| wr_data_i | input | N_SRC | register write data |
| irq_ack_i | input | 1 | CPU acknowledge of the presented source |
| irq_pend_o | output | 1 | an interrupt is presented to the CPU |
| irq_src_o | output | IDX_W | index of the presented source |
| irq_lvl_o | output | 3 | level of the presented source |
| req_flags_o | output | N_SRC | current request flags |

## Verification
The checker keeps its own copy of the enable and the IPL, built only from port writes. It therefore assumes that no state changes except through the write port, the request inputs and the acknowledge. It also assumes that `src_req_i` is low during reset, so that the first sampled request follows a clean release. The acknowledge assertion takes for granted that the CPU acknowledges only the source shown on the outputs in that cycle. The bench drives every input at the falling edge, keeps requests low while in reset, and raises the acknowledge only while the strobe is high, except in the single test that checks an idle acknowledge is ignored.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    localparam int unsigned LVL_W = 3;
    typedef logic [LVL_W-1:0] lvl_t;

    localparam int unsigned ADR_IE   = 0;
    localparam int unsigned ADR_IPL  = 1;
    localparam int unsigned ADR_FCLR = 2;
    localparam int unsigned ADR_LVL0 = 4;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_prio_pkg::*;
#(
    parameter int unsigned N_SRC  = 8,
    parameter int unsigned ADDR_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [LVL_W-1:0]       wr_field,
    output logic                   ie_d_o,
    output lvl_t                   ipl_d_o,
    output lvl_t [N_SRC-1:0]       lvl_d_o
);
    typedef struct packed {
        logic             ie;
        lvl_t             ipl;
        lvl_t [N_SRC-1:0] lvl;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            if (wr_addr == ADDR_W'(ADR_IE))
                cfg_d.ie = wr_field[0];
            if (wr_addr == ADDR_W'(ADR_IPL))
                cfg_d.ipl = wr_field;
            for (int k = 0; k < int'(N_SRC); k++) begin
                if (wr_addr == ADDR_W'(int'(ADR_LVL0) + k))
                    cfg_d.lvl[k] = wr_field;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign ie_d_o  = cfg_d.ie;
    assign ipl_d_o = cfg_d.ipl;
    assign lvl_d_o = cfg_d.lvl;
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int unsigned N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] set_req,
    input  logic [N_SRC-1:0] sw_clr,
    input  logic [N_SRC-1:0] ack_clr,
    output logic [N_SRC-1:0] flags_q_o,
    output logic [N_SRC-1:0] flags_d_o
);
    typedef struct packed {
        logic [N_SRC-1:0] flag;
    } fb_t;

    fb_t fb_d, fb_q;

    // per-bit next state: a fresh request outranks either clear source
    for (genvar k = 0; k < N_SRC; k++) begin : g_bit
        always_comb begin
            fb_d.flag[k] = set_req[k] | (fb_q.flag[k] & ~sw_clr[k] & ~ack_clr[k]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fb_q <= '0;
        else        fb_q <= fb_d;
    end

    assign flags_q_o = fb_q.flag;
    assign flags_d_o = fb_d.flag;
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_prio_pkg::*;
#(
    parameter int unsigned N_SRC = 8,
    parameter int unsigned IDX_W = 3
) (
    input  logic             ie,
    input  lvl_t             ipl,
    input  logic [N_SRC-1:0] flags,
    input  lvl_t [N_SRC-1:0] lvl,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o,
    output lvl_t             lvl_o
);
    logic [N_SRC-1:0] elig;

    for (genvar k = 0; k < N_SRC; k++) begin : g_elig
        assign elig[k] = ie & flags[k] & (lvl[k] > ipl);
    end

    // scan from the top index down; ">=" lets a lower index take a tie
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        lvl_o = '0;
        for (int k = int'(N_SRC) - 1; k >= 0; k--) begin
            if (elig[k] && (lvl[k] >= lvl_o)) begin
                any_o = 1'b1;
                idx_o = IDX_W'(k);
                lvl_o = lvl[k];
            end
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int unsigned N_SRC  = 8,
    localparam int unsigned IDX_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    localparam int unsigned ADDR_W = $clog2(N_SRC + ADR_LVL0)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_req_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [N_SRC-1:0]  wr_data_i,
    input  logic              irq_ack_i,
    output logic              irq_pend_o,
    output logic [IDX_W-1:0]  irq_src_o,
    output logic [LVL_W-1:0]  irq_lvl_o,
    output logic [N_SRC-1:0]  req_flags_o
);
    typedef struct packed {
        logic             pend;
        logic [IDX_W-1:0] src;
        lvl_t             lvl;
    } out_t;

    out_t out_d, out_q;

    logic             ie_nx;
    lvl_t             ipl_nx;
    lvl_t [N_SRC-1:0] lvl_nx;
    logic [N_SRC-1:0] flags_q, flags_nx;
    logic [N_SRC-1:0] sw_clr, ack_clr;
    logic             pk_any;
    logic [IDX_W-1:0] pk_idx;
    lvl_t             pk_lvl;
    logic             keep;

    irq_cfg_regs #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en_i),
        .wr_addr  (wr_addr_i),
        .wr_field (wr_data_i[LVL_W-1:0]),
        .ie_d_o   (ie_nx),
        .ipl_d_o  (ipl_nx),
        .lvl_d_o  (lvl_nx)
    );

    assign sw_clr = (wr_en_i && (wr_addr_i == ADDR_W'(ADR_FCLR))) ? ~wr_data_i : '0;

    for (genvar k = 0; k < N_SRC; k++) begin : g_ack
        assign ack_clr[k] = out_q.pend & irq_ack_i & (out_q.src == IDX_W'(k));
    end

    irq_flag_bank #(.N_SRC(N_SRC)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_req   (src_req_i),
        .sw_clr    (sw_clr),
        .ack_clr   (ack_clr),
        .flags_q_o (flags_q),
        .flags_d_o (flags_nx)
    );

    // decision is taken on next-state values so outputs line up with the state
    irq_pick #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_pick (
        .ie    (ie_nx),
        .ipl   (ipl_nx),
        .flags (flags_nx),
        .lvl   (lvl_nx),
        .any_o (pk_any),
        .idx_o (pk_idx),
        .lvl_o (pk_lvl)
    );

    always_comb begin
        keep = out_q.pend & ~irq_ack_i & ie_nx & flags_nx[out_q.src]
             & (lvl_nx[out_q.src] > ipl_nx);
        if (keep) begin
            out_d     = out_q;
            out_d.lvl = lvl_nx[out_q.src];
        end else begin
            out_d.pend = pk_any;
            out_d.src  = pk_idx;
            out_d.lvl  = pk_lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign irq_pend_o  = out_q.pend;
    assign irq_src_o   = out_q.src;
    assign irq_lvl_o   = out_q.lvl;
    assign req_flags_o = flags_q;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
    import irq_prio_pkg::*;
#(
    parameter int unsigned N_SRC  = 8,
    parameter int unsigned IDX_W  = 3,
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_SRC-1:0]  src_req_i,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] wr_addr_i,
    input logic [N_SRC-1:0]  wr_data_i,
    input logic              irq_ack_i,
    input logic              irq_pend_o,
    input logic [IDX_W-1:0]  irq_src_o,
    input logic [LVL_W-1:0]  irq_lvl_o,
    input logic [N_SRC-1:0]  req_flags_o
);
    logic ie_seen;
    lvl_t ipl_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_seen  <= 1'b0;
            ipl_seen <= '0;
        end else if (wr_en_i) begin
            if (wr_addr_i == ADDR_W'(ADR_IE))  ie_seen  <= wr_data_i[0];
            if (wr_addr_i == ADDR_W'(ADR_IPL)) ipl_seen <= wr_data_i[LVL_W-1:0];
        end
    end

    // R2
    req_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_req_i != '0) |=> ((req_flags_o & $past(src_req_i)) == $past(src_req_i)));

    // R3
    sw_write_clears_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (wr_addr_i == ADDR_W'(ADR_FCLR)) && !(irq_pend_o && irq_ack_i))
        |=> (req_flags_o == (($past(req_flags_o) & $past(wr_data_i)) | $past(src_req_i))));

    // R5
    enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_seen |-> !irq_pend_o);

    // R7
    above_ipl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pend_o |-> (irq_lvl_o > ipl_seen));

    // R6
    presented_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pend_o |-> (req_flags_o[irq_src_o] && (irq_lvl_o != '0)));

    // R10
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend_o && irq_ack_i && !src_req_i[irq_src_o])
        |=> !req_flags_o[$past(irq_src_o)]);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
    .N_SRC  (N_SRC),
    .IDX_W  (IDX_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_req_i   (src_req_i),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .irq_ack_i   (irq_ack_i),
    .irq_pend_o  (irq_pend_o),
    .irq_src_o   (irq_src_o),
    .irq_lvl_o   (irq_lvl_o),
    .req_flags_o (req_flags_o)
);

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src_req_i = '0;
    logic         wr_en_i = 1'b0;
    logic [3:0]   wr_addr_i = '0;
    logic [N-1:0] wr_data_i = '0;
    logic         irq_ack_i = 1'b0;
    logic         irq_pend_o;
    logic [2:0]   irq_src_o;
    logic [2:0]   irq_lvl_o;
    logic [N-1:0] req_flags_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    irq_prio_ctrl #(.N_SRC(N)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_req_i   (src_req_i),
        .wr_en_i     (wr_en_i),
        .wr_addr_i   (wr_addr_i),
        .wr_data_i   (wr_data_i),
        .irq_ack_i   (irq_ack_i),
        .irq_pend_o  (irq_pend_o),
        .irq_src_o   (irq_src_o),
        .irq_lvl_o   (irq_lvl_o),
        .req_flags_o (req_flags_o)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_out(input string req, input int pend, input int src, input int lvl);
        check({req, " pend"}, int'(irq_pend_o), pend);
        if (pend != 0) begin
            check({req, " src"}, int'(irq_src_o), src);
            check({req, " lvl"}, int'(irq_lvl_o), lvl);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; src_req_i = '0; wr_en_i = 1'b0; irq_ack_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = 4'(addr); wr_data_i = N'(data);
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic pulse_req(input int mask);
        @(negedge clk);
        src_req_i = N'(mask);
        @(negedge clk);
        src_req_i = '0;
    endtask

    task automatic pulse_ack();
        @(negedge clk);
        irq_ack_i = 1'b1;
        @(negedge clk);
        irq_ack_i = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 flags", int'(req_flags_o), 0);
        check_out("R1", 0, 0, 0);
        wr(0, 1);
        pulse_req('h01);
        check("R2 flag0", int'(req_flags_o), 'h01);
        check_out("R1 R6 level0 source", 0, 0, 0);
    endtask

    task automatic t_flags();
        do_reset();
        pulse_req('h08);
        check("R2 flag3", int'(req_flags_o), 'h08);
        wr(2, 'hF7);
        check("R3 clear by 0", int'(req_flags_o), 'h00);
        pulse_req('h21);
        wr(2, 'hFF);
        check("R3 write 1 ignored", int'(req_flags_o), 'h21);
        @(negedge clk);
        src_req_i = 'h04; wr_en_i = 1'b1; wr_addr_i = 4'd2; wr_data_i = 'hFB;
        @(negedge clk);
        src_req_i = '0; wr_en_i = 1'b0;
        check("R4 set beats clear", int'(req_flags_o), 'h25);
        wr(2, 'h00);
        check("R3 clear all", int'(req_flags_o), 'h00);
    endtask

    task automatic t_enable();
        do_reset();
        wr(6, 4);
        pulse_req('h04);
        check_out("R5 disabled", 0, 0, 0);
        wr(0, 1);
        check_out("R5 enabled", 1, 2, 4);
        wr(0, 0);
        check_out("R5 disabled again", 0, 0, 0);
        check("R11 flags kept", int'(req_flags_o), 'h04);
    endtask

    task automatic t_ipl();
        do_reset();
        wr(0, 1);
        wr(6, 4);
        pulse_req('h04);
        check_out("R7 ipl0", 1, 2, 4);
        wr(1, 3);
        check_out("R7 ipl3", 1, 2, 4);
        wr(1, 4);
        check_out("R7 equal blocked", 0, 0, 0);
        wr(6, 7);
        check_out("R11 ipl kept after level write", 1, 2, 7);
        wr(1, 7);
        check_out("R7 ipl7 blocks", 0, 0, 0);
        wr(1, 0);
        check_out("R11 level kept after ipl write", 1, 2, 7);
    endtask

    task automatic t_arb();
        do_reset();
        wr(0, 1);
        wr(5, 5);
        wr(8, 5);
        wr(10, 3);
        pulse_req('h52);
        check_out("R8 tie lowest index", 1, 1, 5);
        pulse_ack();
        check("R10 flag1 cleared", int'(req_flags_o), 'h50);
        check_out("R8 R10 next", 1, 4, 5);
        pulse_ack();
        check_out("R8 lower level", 1, 6, 3);
        pulse_ack();
        check("R10 all cleared", int'(req_flags_o), 'h00);
        check_out("R10 none left", 0, 0, 0);
    endtask

    task automatic t_hold();
        do_reset();
        wr(0, 1);
        wr(4, 2);
        pulse_req('h01);
        check_out("R9 first", 1, 0, 2);
        wr(11, 6);
        pulse_req('h80);
        check("R2 flag7", int'(req_flags_o), 'h81);
        check_out("R9 held", 1, 0, 2);
        pulse_ack();
        check_out("R9 R8 after ack", 1, 7, 6);
        check("R10 flag0 cleared", int'(req_flags_o), 'h80);
    endtask

    task automatic t_ack_edge();
        do_reset();
        wr(0, 1);
        pulse_req('h02);
        check_out("R6 level0 not offered", 0, 0, 0);
        pulse_ack();
        check("R10 idle ack ignored", int'(req_flags_o), 'h02);
        wr(5, 3);
        check_out("R6 level set", 1, 1, 3);
        @(negedge clk);
        irq_ack_i = 1'b1; src_req_i = 'h02;
        @(negedge clk);
        irq_ack_i = 1'b0; src_req_i = '0;
        check("R10 re-request kept", int'(req_flags_o), 'h02);
        check_out("R10 re-presented", 1, 1, 3);
    endtask

    initial begin
        t_reset();
        t_flags();
        t_enable();
        t_ipl();
        t_arb();
        t_hold();
        t_ack_edge();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                #200us;
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule